// File: doc/BRIEF.md
# Display Sequencer Register File

This block is the register file behind the sequencer of a VGA-style display controller. Software reaches it through two byte-wide I/O addresses. One address holds an index. The other address is a data window onto the register that the index selects. The block keeps the standard sequencer settings: a reset byte, clocking mode, plane write mask, character map select and memory mode. It also keeps an extended group that sets up two clock synthesizers (a memory PLL and a video PLL) and a synthesizer command byte. The extended group stays locked until a key value is written to a lock register.

The stored values are decoded into signals for the rest of the display pipeline:
- a byte-lane write mask across the memory planes, together with its complement,
- two font base offsets,
- a chained (one plane per address bit pair) addressing flag,
- the raw M, N and R fields of both synthesizers.

Two registered one-cycle pulses tell neighbouring logic about events. One asks for a timing recalculation. The other reports a write to an index that holds no register.

Top module: `vga_seq_regfile`

## Requirements
- R1: A write at the index port address (default 0x3C4) loads the 8-bit index, and a read at that address returns it. Reads and writes at the data port address (default 0x3C5) act on the register the index selects. A read at any other address returns 0x00. Read data is combinational from the current address and state.
- R2: While rst_n is low, every register is zero. The write mask is therefore 0x00000000 and its complement 0xFFFFFFFF. Both font bases and chain4_en are 0, all PLL fields are 0, both pulses are low, and the extended group is locked.
- R3: Index 0x02 keeps only data bits 3:0, one enable per plane, and reads back with bits 7:4 zero. Plane p drives bits 8p+7:8p of plane_wr_mask to 0xFF when enabled and to 0x00 when not. plane_wr_mask_n is the bitwise complement.
- R4: Index 0x03 stores the full byte and reads it back. Map A is {d4,d1,d0} and map B is {d5,d3,d2}. A map's font base is (low two bits × 0x4000) + (high bit × 0x2000), which gives maps 0..7 at 0x0000, 0x4000, 0x8000, 0xC000, 0x2000, 0x6000, 0xA000, 0xE000.
- R5: Index 0x04 stores the full byte and reads it back. chain4_en equals its bit 3 from the cycle after the write.
- R6: The lock register sits at index 0x08 and is always reachable. For any index above 0x08, unless the lock register holds exactly 0x06, a data write has no effect (no state change, no pulse) and a data read returns the index value.
- R7: Index 0x10 (memory PLL) and index 0x12 (video PLL) hold N in bits 4:0 and R in bits 7:5. They read back as N OR (R shifted left by 5). Indices 0x11 and 0x13 hold M in bits 6:0 and read back with bit 7 zero.
- R8: A data write to index 0x15 stores the command byte, which reads back in full, and drives resize_req high for exactly the next cycle.
- R9: A data write to index 0x01 stores the clocking mode byte, which reads back in full. It drives resize_req high for the next cycle only when the new value differs from the stored one.
- R10: Reachable indices that hold no register (0x05-0x07, 0x09-0x0F, 0x14, 0x16-0xFF) read as 0x00. Data writes to them change nothing and drive bad_index high for exactly the next cycle.
- R11: Index 0x00 stores the full byte and reads it back, with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr |
| plane_wr_mask | output | 32 | Per-plane byte-lane write enable mask |
| plane_wr_mask_n | output | 32 | Complement of plane_wr_mask |
| font_a_base | output | 16 | Byte offset of character map A |
| font_b_base | output | 16 | Byte offset of character map B |
| chain4_en | output | 1 | Chained addressing flag |
| mpll_n | output | 5 | Memory PLL N |
| mpll_r | output | 3 | Memory PLL R |
| mpll_m | output | 7 | Memory PLL M |
| vpll_n | output | 5 | Video PLL N |
| vpll_r | output | 3 | Video PLL R |
| vpll_m | output | 7 | Video PLL M |
| resize_req | output | 1 | One-cycle timing recalculation request |
| bad_index | output | 1 | One-cycle flag for a write to an unused index |

## Verification
The bench builds the block with its default parameters: four planes of 8-bit lanes, a 16-bit font offset, the ports at 0x3C4/0x3C5 and a lock key of 0x06. These values put the full 32-bit lane mask, every one of the eight font map positions and the exact key boundary within reach. A behavioural model then walks the whole 8-bit index space while the block is locked and while it is unlocked, so the gate at index 0x08 versus 0x09 and the near-miss key values are exercised against the real encodings. Repeated clocking mode writes with equal and differing values check the resize condition.

// File: rtl/seq_regs_pkg.sv
package seq_regs_pkg;

  localparam logic [7:0] IX_RESET   = 8'h00;
  localparam logic [7:0] IX_CLKMODE = 8'h01;
  localparam logic [7:0] IX_PLNMASK = 8'h02;
  localparam logic [7:0] IX_CHARSEL = 8'h03;
  localparam logic [7:0] IX_MEMMODE = 8'h04;
  localparam logic [7:0] IX_LOCK    = 8'h08;
  localparam logic [7:0] IX_PLL_LO0 = 8'h10;
  localparam logic [7:0] IX_PLLCMD  = 8'h15;

  localparam int PLL_COUNT = 2;

  typedef struct packed {
    logic [6:0] m;
    logic [2:0] r;
    logic [4:0] n;
  } pll_word_t;

  localparam int PLL_W = $bits(pll_word_t);

endpackage

// File: rtl/seq_access_ctl.sv
module seq_access_ctl #(
  parameter int              ADDR_W    = 16,
  parameter logic [15:0]     IDX_PORT  = 16'h03C4,
  parameter logic [15:0]     DATA_PORT = 16'h03C5,
  parameter logic [7:0]      EXT_BASE  = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  input  logic              lock_open,
  output logic [7:0]        idx_q,
  output logic              data_wr,
  output logic              gated
);

  logic       idx_wr;
  logic [7:0] idx_d;

  always_comb begin
    idx_wr  = io_wr && (io_addr == ADDR_W'(IDX_PORT));
    gated   = (idx_q > EXT_BASE) && !lock_open;
    data_wr = io_wr && (io_addr == ADDR_W'(DATA_PORT)) && !gated;
    idx_d   = idx_q;
    if (idx_wr) idx_d = io_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assert_index_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (idx_q == $past(io_wdata)));

endmodule

// File: rtl/seq_std_regs.sv
module seq_std_regs
  import seq_regs_pkg::*;
#(
  parameter int NUM_PLANES = 4,
  parameter int LANE_W     = 8,
  parameter int FONT_AW    = 16,
  localparam int MASK_W    = NUM_PLANES * LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_wr,
  input  logic [7:0]         idx,
  input  logic [7:0]         wdata,
  output logic               hit,
  output logic [7:0]         rd_val,
  output logic               clk_change,
  output logic [7:0]         clkmode_q,
  output logic [MASK_W-1:0]  plane_mask,
  output logic [MASK_W-1:0]  plane_mask_n,
  output logic [FONT_AW-1:0] font_a,
  output logic [FONT_AW-1:0] font_b,
  output logic               chain4
);

  localparam int FONT_PAD = FONT_AW - 3;

  logic [7:0]            rst_q, rst_d;
  logic [7:0]            clkmode_d;
  logic [NUM_PLANES-1:0] pmask_q, pmask_d;
  logic [7:0]            csel_q, csel_d;
  logic [7:0]            mmode_q, mmode_d;
  logic                  we_rst, we_clk, we_pm, we_cs, we_mm;
  logic [2:0]            sel_a, sel_b;

  function automatic logic [FONT_AW-1:0] map_base(input logic [2:0] sel);
    return {sel[1:0], sel[2], {FONT_PAD{1'b0}}};
  endfunction

  always_comb begin
    we_rst = data_wr && (idx == IX_RESET);
    we_clk = data_wr && (idx == IX_CLKMODE);
    we_pm  = data_wr && (idx == IX_PLNMASK);
    we_cs  = data_wr && (idx == IX_CHARSEL);
    we_mm  = data_wr && (idx == IX_MEMMODE);
    hit    = (idx <= IX_MEMMODE);

    rst_d     = we_rst ? wdata : rst_q;
    clkmode_d = we_clk ? wdata : clkmode_q;
    pmask_d   = we_pm  ? wdata[NUM_PLANES-1:0] : pmask_q;
    csel_d    = we_cs  ? wdata : csel_q;
    mmode_d   = we_mm  ? wdata : mmode_q;

    clk_change = we_clk && (wdata != clkmode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q     <= '0;
      clkmode_q <= '0;
      pmask_q   <= '0;
      csel_q    <= '0;
      mmode_q   <= '0;
    end else begin
      rst_q     <= rst_d;
      clkmode_q <= clkmode_d;
      pmask_q   <= pmask_d;
      csel_q    <= csel_d;
      mmode_q   <= mmode_d;
    end
  end

  always_comb begin
    case (idx)
      IX_RESET:   rd_val = rst_q;
      IX_CLKMODE: rd_val = clkmode_q;
      IX_PLNMASK: rd_val = 8'(pmask_q);
      IX_CHARSEL: rd_val = csel_q;
      IX_MEMMODE: rd_val = mmode_q;
      default:    rd_val = 8'h00;
    endcase
  end

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_lane
    assign plane_mask[p*LANE_W +: LANE_W] = {LANE_W{pmask_q[p]}};
  end
  assign plane_mask_n = ~plane_mask;

  assign sel_a  = {csel_q[4], csel_q[1:0]};
  assign sel_b  = {csel_q[5], csel_q[3:2]};
  assign font_a = map_base(sel_a);
  assign font_b = map_base(sel_b);
  assign chain4 = mmode_q[3];

  assert_mask_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we_pm |=> (plane_mask[LANE_W-1:0] == {LANE_W{$past(wdata[0])}}));

  assert_chain_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_mm |=> (chain4 == $past(wdata[3])));

endmodule

// File: rtl/seq_ext_regs.sv
module seq_ext_regs
  import seq_regs_pkg::*;
#(
  parameter logic [7:0] UNLOCK_KEY = 8'h06
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       data_wr,
  input  logic [7:0]                 idx,
  input  logic [7:0]                 wdata,
  output logic                       lock_open,
  output logic                       hit,
  output logic [7:0]                 rd_val,
  output logic                       cmd_wr,
  output logic [PLL_COUNT*PLL_W-1:0] pll_flat
);

  logic [7:0] lock_q, lock_d;
  logic [7:0] cmd_q, cmd_d;

  always_comb begin
    cmd_wr = data_wr && (idx == IX_PLLCMD);
    lock_d = (data_wr && (idx == IX_LOCK)) ? wdata : lock_q;
    cmd_d  = cmd_wr ? wdata : cmd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      cmd_q  <= '0;
    end else begin
      lock_q <= lock_d;
      cmd_q  <= cmd_d;
    end
  end

  assign lock_open = (lock_q == UNLOCK_KEY);

  for (genvar g = 0; g < PLL_COUNT; g++) begin : g_pll
    localparam logic [7:0] IX_LO = IX_PLL_LO0 + 8'(2 * g);
    localparam logic [7:0] IX_HI = IX_LO + 8'd1;
    pll_word_t word_q, word_d;

    always_comb begin
      word_d = word_q;
      if (data_wr && (idx == IX_LO)) begin
        word_d.n = wdata[4:0];
        word_d.r = wdata[7:5];
      end
      if (data_wr && (idx == IX_HI)) word_d.m = wdata[6:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign pll_flat[g*PLL_W +: PLL_W] = word_q;
  end

  always_comb begin
    pll_word_t w;
    hit    = (idx == IX_LOCK) || (idx == IX_PLLCMD);
    rd_val = 8'h00;
    if (idx == IX_LOCK)   rd_val = lock_q;
    if (idx == IX_PLLCMD) rd_val = cmd_q;
    for (int g = 0; g < PLL_COUNT; g++) begin
      w = pll_word_t'(pll_flat[g*PLL_W +: PLL_W]);
      if (idx == IX_PLL_LO0 + 8'(2 * g)) begin
        hit    = 1'b1;
        rd_val = 8'(w.n) | (8'(w.r) << 5);
      end
      if (idx == IX_PLL_LO0 + 8'(2 * g + 1)) begin
        hit    = 1'b1;
        rd_val = {1'b0, w.m};
      end
    end
  end

  assert_lock_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && (idx == IX_LOCK)) |=> (lock_open == ($past(wdata) == UNLOCK_KEY)));

endmodule

// File: rtl/vga_seq_regfile.sv
module vga_seq_regfile
  import seq_regs_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] IDX_PORT   = 16'h03C4,
  parameter logic [15:0] DATA_PORT  = 16'h03C5,
  parameter int          NUM_PLANES = 4,
  parameter int          LANE_W     = 8,
  parameter int          FONT_AW    = 16,
  parameter logic [7:0]  UNLOCK_KEY = 8'h06,
  localparam int         MASK_W     = NUM_PLANES * LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic               io_wr,
  input  logic [7:0]         io_wdata,
  output logic [7:0]         io_rdata,
  output logic [MASK_W-1:0]  plane_wr_mask,
  output logic [MASK_W-1:0]  plane_wr_mask_n,
  output logic [FONT_AW-1:0] font_a_base,
  output logic [FONT_AW-1:0] font_b_base,
  output logic               chain4_en,
  output logic [4:0]         mpll_n,
  output logic [2:0]         mpll_r,
  output logic [6:0]         mpll_m,
  output logic [4:0]         vpll_n,
  output logic [2:0]         vpll_r,
  output logic [6:0]         vpll_m,
  output logic               resize_req,
  output logic               bad_index
);

  logic [7:0]                 idx;
  logic                       data_wr, gated, lock_open;
  logic                       std_hit, ext_hit, clk_change, cmd_wr;
  logic [7:0]                 std_rd, ext_rd, clkmode;
  logic [PLL_COUNT*PLL_W-1:0] pll_flat;
  logic                       resize_d, bad_d;
  pll_word_t                  mpll, vpll;

  seq_access_ctl #(
    .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT), .EXT_BASE(IX_LOCK)
  ) u_access (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .lock_open(lock_open), .idx_q(idx), .data_wr(data_wr), .gated(gated)
  );

  seq_std_regs #(
    .NUM_PLANES(NUM_PLANES), .LANE_W(LANE_W), .FONT_AW(FONT_AW)
  ) u_std (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .idx(idx), .wdata(io_wdata),
    .hit(std_hit), .rd_val(std_rd), .clk_change(clk_change), .clkmode_q(clkmode),
    .plane_mask(plane_wr_mask), .plane_mask_n(plane_wr_mask_n),
    .font_a(font_a_base), .font_b(font_b_base), .chain4(chain4_en)
  );

  seq_ext_regs #(
    .UNLOCK_KEY(UNLOCK_KEY)
  ) u_ext (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .idx(idx), .wdata(io_wdata),
    .lock_open(lock_open), .hit(ext_hit), .rd_val(ext_rd), .cmd_wr(cmd_wr),
    .pll_flat(pll_flat)
  );

  assign mpll   = pll_word_t'(pll_flat[0 +: PLL_W]);
  assign vpll   = pll_word_t'(pll_flat[PLL_W +: PLL_W]);
  assign mpll_n = mpll.n;
  assign mpll_r = mpll.r;
  assign mpll_m = mpll.m;
  assign vpll_n = vpll.n;
  assign vpll_r = vpll.r;
  assign vpll_m = vpll.m;

  always_comb begin
    io_rdata = 8'h00;
    if (io_addr == ADDR_W'(IDX_PORT)) begin
      io_rdata = idx;
    end else if (io_addr == ADDR_W'(DATA_PORT)) begin
      if (gated)        io_rdata = idx;
      else if (std_hit) io_rdata = std_rd;
      else if (ext_hit) io_rdata = ext_rd;
    end
  end

  always_comb begin
    resize_d = clk_change || cmd_wr;
    bad_d    = data_wr && !std_hit && !ext_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resize_req <= 1'b0;
      bad_index  <= 1'b0;
    end else begin
      resize_req <= resize_d;
      bad_index  <= bad_d;
    end
  end

  assert_locked_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && (io_addr == ADDR_W'(DATA_PORT)) && (idx > IX_LOCK) && !lock_open)
      |=> ($stable(pll_flat) && !resize_req && !bad_index));

  assert_resize_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resize_req |-> $past(io_wr && (io_addr == ADDR_W'(DATA_PORT))));

  assert_same_clock_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && (io_addr == ADDR_W'(DATA_PORT)) && (idx == IX_CLKMODE) && (io_wdata == clkmode))
      |=> !resize_req);

  assert_bad_index_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_index |-> $past(io_wr && (io_addr == ADDR_W'(DATA_PORT))));

  assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(resize_req && bad_index));

endmodule

// File: tb/sim_vga_seq_regfile.sv
module sim_vga_seq_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic [31:0] plane_wr_mask, plane_wr_mask_n;
  logic [15:0] font_a_base, font_b_base;
  logic        chain4_en;
  logic [4:0]  mpll_n, vpll_n;
  logic [2:0]  mpll_r, vpll_r;
  logic [6:0]  mpll_m, vpll_m;
  logic        resize_req, bad_index;

  always #5 clk = ~clk;

  vga_seq_regfile u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .plane_wr_mask(plane_wr_mask), .plane_wr_mask_n(plane_wr_mask_n),
    .font_a_base(font_a_base), .font_b_base(font_b_base), .chain4_en(chain4_en),
    .mpll_n(mpll_n), .mpll_r(mpll_r), .mpll_m(mpll_m),
    .vpll_n(vpll_n), .vpll_r(vpll_r), .vpll_m(vpll_m),
    .resize_req(resize_req), .bad_index(bad_index)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit live    = 0;
  bit done    = 0;

  // behavioural model state
  int m_idx;
  int m_reg [256];
  int m_rs, m_bad;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic bit m_locked_gate();
    return (m_idx > 8) && (m_reg[8] != 6);
  endfunction

  function automatic int exp_read(input int a);
    if (a == 'h3C4) return m_idx;
    if (a != 'h3C5) return 0;
    if (m_locked_gate()) return m_idx;
    case (m_idx)
      0, 1, 2, 3, 4, 8, 16, 18, 21: return m_reg[m_idx];
      17, 19:                       return m_reg[m_idx] & 127;
      default:                      return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_rs = 0; m_bad = 0;
      for (int i = 0; i < 256; i++) m_reg[i] = 0;
    end else begin
      m_rs = 0; m_bad = 0;
      if (io_wr && io_addr == 16'h3C4) m_idx = io_wdata;
      else if (io_wr && io_addr == 16'h3C5 && !m_locked_gate()) begin
        case (m_idx)
          0, 3, 4, 8, 16, 17, 18, 19: m_reg[m_idx] = io_wdata;
          1: begin
            if (io_wdata != m_reg[1]) m_rs = 1;
            m_reg[1] = io_wdata;
          end
          2:  m_reg[2] = io_wdata & 15;
          21: begin m_reg[21] = io_wdata; m_rs = 1; end
          default: m_bad = 1;
        endcase
      end
    end
    live = 1;
  end

  // per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    logic [31:0] em;
    int a, b;
    #1;
    if (live && !done) begin
      em = 0;
      for (int p = 0; p < 4; p++) if ((m_reg[2] >> p) & 1) em |= 32'hFF << (8 * p);
      a = (m_reg[3] & 3) * 16384 + ((m_reg[3] >> 4) & 1) * 8192;
      b = ((m_reg[3] >> 2) & 3) * 16384 + ((m_reg[3] >> 5) & 1) * 8192;
      chk("R1 io_rdata", 32'(io_rdata), 32'(exp_read(io_addr)));
      chk("R3 plane_wr_mask", plane_wr_mask, em);
      chk("R3 plane_wr_mask_n", plane_wr_mask_n, ~em);
      chk("R4 font_a_base", 32'(font_a_base), 32'(a));
      chk("R4 font_b_base", 32'(font_b_base), 32'(b));
      chk("R5 chain4_en", 32'(chain4_en), 32'((m_reg[4] >> 3) & 1));
      chk("R7 mpll_n", 32'(mpll_n), 32'(m_reg[16] & 31));
      chk("R7 mpll_r", 32'(mpll_r), 32'((m_reg[16] >> 5) & 7));
      chk("R7 mpll_m", 32'(mpll_m), 32'(m_reg[17] & 127));
      chk("R7 vpll_n", 32'(vpll_n), 32'(m_reg[18] & 31));
      chk("R7 vpll_r", 32'(vpll_r), 32'((m_reg[18] >> 5) & 7));
      chk("R7 vpll_m", 32'(vpll_m), 32'(m_reg[19] & 127));
      chk("R8 R9 resize_req", 32'(resize_req), 32'(m_rs));
      chk("R10 bad_index", 32'(bad_index), 32'(m_bad));
    end
  end

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic seq_wr(input logic [7:0] ix, input logic [7:0] d);
    bus_wr(16'h3C4, ix);
    bus_wr(16'h3C5, d);
  endtask

  task automatic seq_rd(input logic [7:0] ix, input logic [7:0] exp, input string tag);
    bus_wr(16'h3C4, ix);
    io_addr = 16'h3C5;
    #2;
    chk(tag, 32'(io_rdata), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R2 mask at reset", plane_wr_mask, 32'h0);
    chk("R2 mask_n at reset", plane_wr_mask_n, 32'hFFFFFFFF);
    chk("R2 chain4 at reset", 32'(chain4_en), 0);
    @(negedge clk); rst_n = 1'b1;

    // R11 reset byte
    seq_rd(8'h00, 8'h00, "R11 reset byte initial");
    seq_wr(8'h00, 8'hA5);
    seq_rd(8'h00, 8'hA5, "R11 reset byte readback");
    // R3 map mask
    seq_wr(8'h02, 8'h5A);
    #2 chk("R3 mask 0xA", plane_wr_mask, 32'hFF00FF00);
    chk("R3 mask_n 0xA", plane_wr_mask_n, 32'h00FF00FF);
    seq_rd(8'h02, 8'h0A, "R3 mask readback");
    // R4 char map select: A=5 -> 0x6000, B=4 -> 0x2000
    seq_wr(8'h03, 8'h31);
    #2 chk("R4 map A 5", 32'(font_a_base), 32'h6000);
    chk("R4 map B 4", 32'(font_b_base), 32'h2000);
    seq_wr(8'h03, 8'h2F);
    #2 chk("R4 map A 3", 32'(font_a_base), 32'hC000);
    chk("R4 map B 7", 32'(font_b_base), 32'hE000);
    // R5 chain
    seq_wr(8'h04, 8'h08);
    #2 chk("R5 chain set", 32'(chain4_en), 1);
    seq_wr(8'h04, 8'hF7);
    #2 chk("R5 chain clear", 32'(chain4_en), 0);
    // R9 clocking mode
    seq_wr(8'h01, 8'h21);
    #2 chk("R9 differ pulse", 32'(resize_req), 1);
    bus_wr(16'h3C5, 8'h21);
    #2 chk("R9 same no pulse", 32'(resize_req), 0);
    // R6 locked extended group
    seq_wr(8'h10, 8'hFF);
    #2 chk("R6 locked write ignored", 32'(mpll_n), 0);
    seq_rd(8'h15, 8'h15, "R6 locked read returns index");
    seq_wr(8'h08, 8'h07);
    seq_rd(8'h11, 8'h11, "R6 near key stays locked");
    seq_wr(8'h08, 8'h06);
    // R7 PLL fields
    seq_wr(8'h10, 8'hE3);
    seq_rd(8'h10, 8'hE3, "R7 mpll low readback");
    seq_wr(8'h13, 8'hFF);
    seq_rd(8'h13, 8'h7F, "R7 vpll high bit7 zero");
    // R8 command
    seq_wr(8'h15, 8'h3C);
    #2 chk("R8 cmd pulse", 32'(resize_req), 1);
    @(negedge clk); #2 chk("R8 pulse one cycle", 32'(resize_req), 0);
    // R10 unused index
    seq_wr(8'h14, 8'h55);
    #2 chk("R10 bad pulse", 32'(bad_index), 1);
    seq_rd(8'h14, 8'h00, "R10 unused reads zero");
    bus_wr(16'h3C6, 8'h12);
    #2 chk("R1 other address reads zero", 32'(io_rdata), 0);

    // broad stimulus compared every clock by the model
    for (int it = 0; it < 6000; it++) begin
      int k;
      logic [7:0] ix, d;
      k = $urandom_range(0, 9);
      d = 8'($urandom_range(0, 255));
      case ($urandom_range(0, 3))
        0:       ix = 8'($urandom_range(0, 255));
        1:       ix = 8'($urandom_range(0, 5));
        default: ix = 8'($urandom_range(8, 22));
      endcase
      if (k == 0)      seq_wr(8'h08, ($urandom_range(0, 1) != 0) ? 8'h06 : d);
      else if (k < 5)  seq_wr(ix, d);
      else if (k == 5) seq_wr(8'h01, m_reg[1][7:0]);
      else if (k == 6) bus_wr(16'h3C3, d);
      else begin
        bus_wr(16'h3C4, ix);
        io_addr = 16'h3C5;
        @(negedge clk);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule